// File: doc/BRIEF.md
# Trigger Timestamp Capture Unit

This block keeps a wide, free-running time count that advances once per cycle of a fast counting clock. The counting clock is multiplied up from a slow reference that every acquisition module receives, so counts kept in separate crates share one time base. A synchronous clear input zeroes the count, which lets all modules start from a common epoch. The reference clock is also forwarded to an output so it can be daisy-chained to the next module.

An external trigger arrives asynchronously. It is brought into the counting clock domain by a chain of flip-flops, and each rising edge writes the count of that moment into a capture queue. A host later drains the queue through a small register-style read port. Each entry is read as 16-bit words, lowest first, and reading the last word removes the entry. The queue level and its empty and full state are visible at all times. A trigger that finds the queue full is not silently dropped: a sticky overflow flag is set and a lost-trigger counter advances. A host strobe clears both.

Top module: `tstamp_capture`

## Requirements
- R1: With `ts_clear` low, `ts_value` increases by exactly one on every `clk` edge and wraps from all-ones to zero.
- R2: When `ts_clear` is high at a `clk` edge, `ts_value` is zero after that edge, whatever the count was.
- R3: If `trig_in` is first sampled high at edge k after being low, one entry is written at edge k+2, holding the `ts_value` shown between edges k+1 and k+2. A level held high for any number of cycles writes only one entry. Pulses spaced two or more cycles apart each write their own entry.
- R4: A capture whose write edge also has `ts_clear` high stores zero.
- R5: While the queue is not empty, `rd_data` shows bits [15:0] of the oldest entry for `rd_sel`=0, bits [31:16] for `rd_sel`=1 and bits [47:32] for `rd_sel`=2. While it is empty, `rd_data` is zero.
- R6: `rd_en` high with `rd_sel`=2 on a non-empty queue removes the oldest entry at that edge. `rd_en` with `rd_sel`=0 or 1, or with an empty queue, leaves the level unchanged.
- R7: `fifo_count` equals the number of stored entries (0 to 512). `fifo_empty` is high exactly at 0 and `fifo_full` exactly at the depth.
- R8: A capture that finds the queue full with no removal in the same cycle stores nothing, leaves the level unchanged, sets `overflow` (which stays set) and raises `lost_count` by one, saturating at its maximum.
- R9: A `ovf_clr` pulse clears `overflow` and `lost_count` to zero.
- R10: Entries leave in capture order. A capture in the same cycle as a removal on a full queue is stored, with no loss counted.
- R11: `ref_clk_out` follows `ref_clk_in` with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, multiplied from the shared reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_in | input | 1 | Shared reference clock |
| ref_clk_out | output | 1 | Reference clock forwarded unchanged |
| ts_clear | input | 1 | Synchronous clear of the time count |
| trig_in | input | 1 | Asynchronous trigger, rising edge captures |
| ts_value | output | 48 | Current time count |
| rd_sel | input | 2 | Word select for the oldest entry: 0 low, 1 middle, 2 high |
| rd_en | input | 1 | Read strobe; with rd_sel=2 it removes the entry |
| rd_data | output | 16 | Selected word of the oldest entry |
| ovf_clr | input | 1 | Clears overflow and lost_count |
| fifo_empty | output | 1 | Queue holds no entries |
| fifo_full | output | 1 | Queue holds the maximum number of entries |
| fifo_count | output | 10 | Number of stored entries |
| overflow | output | 1 | Sticky: a trigger was lost to a full queue |
| lost_count | output | 16 | Number of triggers lost since the last clear |

## Verification
The embedded properties assume that `ts_clear`, `rd_en`, `rd_sel` and `ovf_clr` are synchronous to `clk`. They also assume that `trig_in` stays low or high for at least one full cycle, so the single-pulse check on the edge detector holds. The stimulus changes every input only on the falling edge of `clk`, and it builds triggers as whole-cycle pulses or long levels. Expected capture values are derived as the count seen just before the trigger rises plus the two synchroniser cycles, or from the spacing of the pulses, never by reading internal state. The bench shrinks the queue to eight entries so that full, overflow and the combined read-and-capture case are reached quickly. A second instance with a 12-bit count is used to show the wrap.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   // word select codes on the host read port
   typedef enum logic [1:0] {
      SEL_LO  = 2'd0,
      SEL_MID = 2'd1,
      SEL_HI  = 2'd2,
      SEL_RSV = 2'd3
   } word_sel_e;

   // number of host words needed to carry a count of width tsw
   function automatic int words_for(input int tsw, input int ww);
      return (tsw + ww - 1) / ww;
   endfunction

endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
   parameter int TS_W = 48
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   output logic [TS_W-1:0] count
);

   if (TS_W < 2) begin : g_bad_w
      $error("tsc_counter: TS_W must be at least 2");
   end

   logic [TS_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count_q <= '0;
      else if (clear)  count_q <= '0;
      else             count_q <= count_q + 1'b1;
   end

   assign count = count_q;

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> count_q == TS_W'($past(count_q) + 1'b1)); // R1

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> count_q == '0); // R2

endmodule

// File: rtl/tsc_trig_sync.sv
module tsc_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tsc_trig_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise = chain_q[STAGES-1] & ~last_q;

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R3

endmodule

// File: rtl/tsc_fifo.sv
module tsc_fifo #(
   parameter int DW    = 48,
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] level,
   output logic          dropped
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tsc_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr_q, rptr_q;
   logic [CW-1:0] level_q;
   logic          do_pop, do_push;

   assign empty   = (level_q == '0);
   assign full    = (level_q == CW'(DEPTH));
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);
   assign dropped = push & ~do_push;

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         level_q <= '0;
      end else begin
         if (do_push) wptr_q <= wptr_q + 1'b1;
         if (do_pop)  rptr_q <= rptr_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level_q <= level_q + 1'b1;
            2'b01:   level_q <= level_q - 1'b1;
            default: level_q <= level_q;
         endcase
      end
   end

   assign head  = mem[rptr_q];
   assign level = level_q;

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= CW'(DEPTH)); // R7

   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      full && !pop |=> level_q == $past(level_q)); // R8

   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      empty && !push |=> level_q == '0); // R6

   AST_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop && !full |=> level_q == $past(level_q) + 1'b1); // R10

   AST_WPTR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (wptr_q - rptr_q) == level_q[AW-1:0]); // R7

endmodule

// File: rtl/tsc_loss_track.sv
module tsc_loss_track #(
   parameter int LOST_W   = 16,
   parameter bit LOST_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lost_evt,
   input  logic              clr,
   output logic              overflow,
   output logic [LOST_W-1:0] lost_count
);

   if (LOST_W < 1) begin : g_bad_lw
      $error("tsc_loss_track: LOST_W must be at least 1");
   end

   logic              ovf_q;
   logic [LOST_W-1:0] lost_q;
   logic [LOST_W-1:0] lost_inc;

   if (LOST_SAT) begin : g_sat
      assign lost_inc = (&lost_q) ? lost_q : lost_q + 1'b1;
   end else begin : g_wrap
      assign lost_inc = lost_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q  <= 1'b0;
         lost_q <= '0;
      end else if (clr) begin
         ovf_q  <= lost_evt;
         lost_q <= LOST_W'(lost_evt);
      end else if (lost_evt) begin
         ovf_q  <= 1'b1;
         lost_q <= lost_inc;
      end
   end

   assign overflow   = ovf_q;
   assign lost_count = lost_q;

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q && !clr |=> ovf_q); // R8

   AST_LOST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !lost_evt |=> !ovf_q && lost_q == '0); // R9

   AST_LOST_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      lost_evt |=> ovf_q && lost_q != '0); // R8

endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
   import tsc_pkg::*;
#(
   parameter int  TS_W        = 48,
   parameter int  DEPTH       = 512,
   parameter int  SYNC_STAGES = 2,
   parameter int  WORD_W      = 16,
   parameter int  LOST_W      = 16,
   parameter bit  LOST_SAT    = 1'b1,
   localparam int CW          = $clog2(DEPTH + 1),
   localparam int NWORDS      = words_for(TS_W, WORD_W),
   localparam int PAD_W       = NWORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_clk_in,
   output logic              ref_clk_out,
   input  logic              ts_clear,
   input  logic              trig_in,
   output logic [TS_W-1:0]   ts_value,
   input  logic [1:0]        rd_sel,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   input  logic              ovf_clr,
   output logic              fifo_empty,
   output logic              fifo_full,
   output logic [CW-1:0]     fifo_count,
   output logic              overflow,
   output logic [LOST_W-1:0] lost_count
);

   if (NWORDS < 1 || NWORDS > 3) begin : g_bad_words
      $error("tstamp_capture: TS_W must fit in one to three host words");
   end

   localparam logic [1:0] LAST_SEL = 2'(NWORDS - 1);

   // reference forwarding
   assign ref_clk_out = ref_clk_in;

   // time count
   logic [TS_W-1:0] count;

   tsc_counter #(.TS_W(TS_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (ts_clear),
      .count (count)
   );

   assign ts_value = count;

   // trigger edge
   logic trig_rise;

   tsc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (trig_in),
      .rise     (trig_rise)
   );

   // capture value: clear wins over counting in the same cycle
   logic [TS_W-1:0] cap_value;
   assign cap_value = ts_clear ? '0 : count;

   // capture queue
   logic [TS_W-1:0] head;
   logic            pop_req;
   logic            drop;

   assign pop_req = rd_en & (rd_sel == LAST_SEL);

   tsc_fifo #(.DW(TS_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (trig_rise),
      .wdata   (cap_value),
      .pop     (pop_req),
      .head    (head),
      .empty   (fifo_empty),
      .full    (fifo_full),
      .level   (fifo_count),
      .dropped (drop)
   );

   // loss bookkeeping
   tsc_loss_track #(.LOST_W(LOST_W), .LOST_SAT(LOST_SAT)) u_loss (
      .clk        (clk),
      .rst_n      (rst_n),
      .lost_evt   (drop),
      .clr        (ovf_clr),
      .overflow   (overflow),
      .lost_count (lost_count)
   );

   // host word mux
   logic [PAD_W-1:0]  head_pad;
   logic [WORD_W-1:0] words [4];

   assign head_pad = PAD_W'(head);

   for (genvar w = 0; w < 4; w++) begin : g_word
      if (w < NWORDS) begin : g_real
         assign words[w] = head_pad[w*WORD_W +: WORD_W];
      end else begin : g_none
         assign words[w] = '0;
      end
   end

   assign rd_data = fifo_empty ? '0 : words[rd_sel];

   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> rd_data == '0); // R5

   AST_PARTIAL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_sel != LAST_SEL && !trig_rise |=> fifo_count == $past(fifo_count)); // R6

   AST_CLEAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_rise && ts_clear && fifo_empty |=> rd_data == '0 && !fifo_empty); // R4

endmodule

// File: tb/tstamp_capture_test.sv
`timescale 1ns/1ps
module tstamp_capture_test;

   localparam int TS_W  = 48;
   localparam int DEPTH = 8;
   localparam int CW    = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_clk_in = 1'b0;
   logic ts_clear = 1'b0;
   logic trig_in = 1'b0;
   logic [1:0] rd_sel = 2'd0;
   logic rd_en = 1'b0;
   logic ovf_clr = 1'b0;

   logic ref_clk_out;
   logic [TS_W-1:0] ts_value;
   logic [15:0] rd_data;
   logic fifo_empty, fifo_full, overflow;
   logic [CW-1:0] fifo_count;
   logic [15:0] lost_count;

   logic ref_w;
   logic [11:0] ts_w;
   logic [15:0] rd_w;
   logic emp_w, full_w, ovf_w;
   logic [2:0] cnt_w;
   logic [15:0] lost_w;

   always #2.5 clk = ~clk;

   tstamp_capture #(.TS_W(TS_W), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .ref_clk_out(ref_clk_out),
      .ts_clear(ts_clear), .trig_in(trig_in), .ts_value(ts_value),
      .rd_sel(rd_sel), .rd_en(rd_en), .rd_data(rd_data), .ovf_clr(ovf_clr),
      .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_count(fifo_count),
      .overflow(overflow), .lost_count(lost_count)
   );

   // narrow-count instance used only to show the wrap
   tstamp_capture #(.TS_W(12), .DEPTH(4)) uut_w (
      .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .ref_clk_out(ref_w),
      .ts_clear(ts_clear), .trig_in(1'b0), .ts_value(ts_w),
      .rd_sel(2'd0), .rd_en(1'b0), .rd_data(rd_w), .ovf_clr(1'b0),
      .fifo_empty(emp_w), .fifo_full(full_w), .fifo_count(cnt_w),
      .overflow(ovf_w), .lost_count(lost_w)
   );

   int total = 0;
   int bad = 0;

   logic [47:0] expv [0:63];
   int nexp = 0;
   int rdix = 0;

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   // caller is at a falling edge; rising trigger, capture = count now + 2
   task automatic fire(input int hold, input bit keep);
      logic [47:0] t0;
      t0 = ts_value;
      trig_in = 1'b1;
      if (keep) begin
         expv[nexp] = t0 + 48'd2;
         nexp++;
      end
      repeat (hold) @(negedge clk);
      trig_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic read_entry(output logic [47:0] v);
      rd_sel = 2'd0; #1 v[15:0] = rd_data;
      rd_sel = 2'd1; #1 v[31:16] = rd_data;
      rd_sel = 2'd2; rd_en = 1'b1; #1 v[47:32] = rd_data;
      @(negedge clk);
      rd_en = 1'b0; rd_sel = 2'd0;
   endtask

   task automatic drain_check(input string tag);
      logic [47:0] v;
      while (!fifo_empty) begin
         read_entry(v);
         check(tag, v, expv[rdix]);
         rdix++;
      end
      check({tag, " all read"}, rdix, nexp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [47:0] v;
      logic [47:0] t0;

      repeat (3) @(negedge clk);
      // reset state
      check("R7 reset empty", fifo_empty, 1);
      check("R7 reset full", fifo_full, 0);
      check("R7 reset count", fifo_count, 0);
      check("R8 reset overflow", overflow, 0);
      check("R9 reset lost", lost_count, 0);
      check("R1 reset count value", ts_value, 0);
      check("R5 reset rd_data", rd_data, 0);
      rst_n = 1'b1;

      // R11 reference forwarding
      for (int i = 0; i < 4; i++) begin
         ref_clk_in = ~ref_clk_in; #0.5;
         check("R11 ref forward", ref_clk_out, ref_clk_in);
      end
      @(negedge clk);

      // R2 clear, R1 count sweep and wrap
      repeat (7) @(negedge clk);
      check("R1 count nonzero before clear", ts_value != 0, 1);
      ts_clear = 1'b1;
      @(negedge clk);
      check("R2 count zero after clear", ts_value, 0);
      ts_clear = 1'b0;
      for (int k = 1; k <= 9; k++) begin
         @(negedge clk);
         check("R1 count step", ts_value, k);
      end
      repeat (4095 - 9) @(negedge clk);
      check("R1 narrow count at max", ts_w, 12'hfff);
      check("R1 wide count at 4095", ts_value, 4095);
      @(negedge clk);
      check("R1 narrow count wraps", ts_w, 0);
      check("R1 wide count no wrap", ts_value, 4096);

      // R3 single capture on a long level, value = count + 2
      fire(20, 1);
      check("R3 long level one entry", fifo_count, 1);
      check("R7 not empty", fifo_empty, 0);
      // R5 word layout and R6 partial reads do not pop
      rd_sel = 2'd0; rd_en = 1'b1; #1;
      check("R5 low word", rd_data, expv[0][15:0]);
      @(negedge clk);
      rd_sel = 2'd1; #1;
      check("R5 mid word", rd_data, expv[0][31:16]);
      @(negedge clk);
      rd_en = 1'b0;
      check("R6 partial reads keep entry", fifo_count, 1);
      drain_check("R10 single entry");
      check("R7 empty after drain", fifo_empty, 1);

      // R6 pop on empty ignored
      rd_sel = 2'd2; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; rd_sel = 2'd0;
      check("R6 pop on empty", fifo_count, 0);
      check("R5 empty read zero", rd_data, 0);

      // R4 capture coinciding with clear records zero
      trig_in = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      ts_clear = 1'b1;
      @(negedge clk);
      ts_clear = 1'b0;
      check("R2 clear during capture", ts_value, 0);
      expv[nexp] = 48'd0; nexp++;
      trig_in = 1'b0;
      repeat (4) @(negedge clk);
      check("R4 one entry", fifo_count, 1);
      drain_check("R4 zero captured");

      // R3 pulse bursts at several spacings
      for (int g = 2; g <= 5; g++) begin
         t0 = ts_value;
         for (int i = 0; i < 3; i++) begin
            expv[nexp] = t0 + 48'd2 + 48'(g * i); nexp++;
            trig_in = 1'b1;
            @(negedge clk);
            trig_in = 1'b0;
            repeat (g - 1) @(negedge clk);
         end
         repeat (4) @(negedge clk);
         check("R3 burst entries", fifo_count, 3);
         drain_check("R3 burst spacing");
      end

      // fill to full, then overflow
      for (int i = 0; i < DEPTH; i++) fire(1 + (i % 3), 1);
      check("R7 full flag", fifo_full, 1);
      check("R7 full count", fifo_count, DEPTH);
      for (int i = 0; i < 3; i++) fire(2, 0);
      check("R8 count held when full", fifo_count, DEPTH);
      check("R8 overflow set", overflow, 1);
      check("R8 lost count", lost_count, 3);

      // R10 capture together with removal on a full queue
      t0 = ts_value;
      trig_in = 1'b1;
      rd_sel = 2'd0; #1 v[15:0] = rd_data;
      rd_sel = 2'd1; #1 v[31:16] = rd_data;
      @(posedge clk); @(posedge clk); @(negedge clk);
      rd_sel = 2'd2; rd_en = 1'b1; #1 v[47:32] = rd_data;
      check("R10 oldest on simultaneous pop", v, expv[rdix]);
      rdix++;
      expv[nexp] = t0 + 48'd2; nexp++;
      @(negedge clk);
      rd_en = 1'b0; rd_sel = 2'd0; trig_in = 1'b0;
      repeat (4) @(negedge clk);
      check("R10 level kept on pop plus capture", fifo_count, DEPTH);
      check("R10 no loss counted", lost_count, 3);
      check("R8 overflow still set", overflow, 1);

      // R9 clear of loss state
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      check("R9 overflow cleared", overflow, 0);
      check("R9 lost cleared", lost_count, 0);
      check("R9 entries untouched", fifo_count, DEPTH);

      drain_check("R10 order after full");
      check("R7 empty at end", fifo_empty, 1);
      check("R8 overflow stays clear", overflow, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule